// File: doc/BRIEF.md
# Double-Buffered Filter Coefficient Store

This block keeps two banks of programmable 16-bit filter coefficients (bank A and bank B) for an audio processing engine that keeps running while software retunes it. A host reaches the store one byte at a time through a register bus that carries a page number, a register address and a data byte. The engine reads whole coefficients by index through a separate datapath port, always from the bank that is active.

Software turns on the double-buffered (adaptive) mode through a control register. While the engine runs in that mode, host writes always land in the bank the engine is not using, whichever bank's pages were addressed. The host then asks for a swap. The swap takes effect on the engine's next sample-start strobe, and the request bit clears itself. When adaptive mode is off, the coefficients are locked against the host for as long as the engine runs. After reset, an internal sweep loads default values into both banks.

A coefficient is in signed 1.15 format, with 0x8000 for -1.0 and 0x7FFF for the largest positive value. The high byte is held in a staging register until the low byte arrives, so the engine never sees half of an update.

Top module: `coef_dbuf_store`

## Requirements
- R1: Coefficient k of a bank sits on page (bank base + k/32), with its high byte at register 8+2*(k mod 32) and its low byte at the next register. The datapath port returns the full 16-bit value of index dp_idx from the active bank on dp_coef, one clock after dp_idx is presented.
- R2: Bank A uses pages 8 and 9 and bank B uses pages 12 and 13. While the engine is stopped, a host read returns the byte of the addressed bank on host_rdata, one clock after host_rd.
- R3: The control register is page 8, register 1. Bit 2 enables adaptive mode and can be written and read back. Bit 1 is read-only. Bits 7..3 read as 0.
- R4: While running is high and adaptive mode is off, host coefficient writes change nothing and host coefficient reads return 0x00.
- R5: In adaptive mode with the engine running, writing 1 to control bit 0 raises a swap request. The request stays pending until the next sample_start pulse, at which point the banks swap and bit 0 reads 0 again.
- R6: Control bit 1 gives the active bank (0 = A, 1 = B) and toggles on each swap, and only on a swap.
- R7: While the engine runs in adaptive mode, host writes and reads go to the inactive bank, whichever bank's pages were addressed.
- R8: While the engine is stopped, writes go to the addressed bank and a swap request is ignored: bit 0 stays 0 and the active bank does not change.
- R9: Writing the high byte alone leaves the stored coefficient unchanged. The full 16-bit value, staged high byte plus new low byte, is stored when the low byte is written.
- R10: After reset, bank A is active and the swap request is 0. Over the first 2*NUM_COEF clocks both banks are loaded with defaults (0x7FFF where k mod 5 is 0, 0x0000 elsewhere), and host accesses made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_page | input | 8 | Host page number |
| host_addr | input | 8 | Host register address within the page |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid one clock after host_rd |
| dp_idx | input | IDX_W | Datapath coefficient index |
| dp_coef | output | 16 | Datapath coefficient from the active bank |
| sample_start | input | 1 | One-clock strobe at each sample period start |
| running | input | 1 | High while the processing engine is active |

## Verification
The assertions assume that sample_start is a single-clock pulse, that running changes only between host transactions, and that host_wr and host_rd are never high in the same cycle. The directed stimulus drives every input on the falling clock edge and raises each strobe for exactly one cycle. It changes running and the adaptive bit only while no byte pair is half written, so the staging register never carries a high byte from one mode into the other.

// File: rtl/coef_store_pkg.sv
package coef_store_pkg;

  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_CTRL = 2'd1,
    RK_HI   = 2'd2,
    RK_LO   = 2'd3
  } rd_kind_t;

  // default content loaded by the post-reset sweep
  function automatic logic [15:0] coef_default(input int unsigned idx);
    return ((idx % 5) == 0) ? 16'h7FFF : 16'h0000;
  endfunction

endpackage

// File: rtl/coef_addr_decode.sv
module coef_addr_decode #(
  parameter int NUM_COEF  = 64,
  parameter int PAGE_A0   = 8,
  parameter int PAGE_B0   = 12,
  parameter int CTRL_REG  = 1,
  parameter int COEF_REG0 = 8,
  localparam int IDX_W    = $clog2(NUM_COEF),
  localparam int PER_PAGE = NUM_COEF / 2
) (
  input  logic [7:0]       page,
  input  logic [7:0]       addr,
  output logic             is_ctrl,
  output logic             is_coef,
  output logic             bank,
  output logic [IDX_W-1:0] idx,
  output logic             is_lo
);
  localparam int SLOT_W = IDX_W - 1;

  logic [8:0] off;
  logic       in_range;
  logic       pg_a0, pg_a1, pg_b0, pg_b1;

  always_comb begin
    off      = {1'b0, addr} - 9'(COEF_REG0);
    in_range = !off[8] && (off < 9'(2 * PER_PAGE));
    pg_a0    = (page == 8'(PAGE_A0));
    pg_a1    = (page == 8'(PAGE_A0 + 1));
    pg_b0    = (page == 8'(PAGE_B0));
    pg_b1    = (page == 8'(PAGE_B0 + 1));
    is_ctrl  = pg_a0 && (addr == 8'(CTRL_REG));
    is_coef  = in_range && (pg_a0 || pg_a1 || pg_b0 || pg_b1);
    bank     = pg_b0 || pg_b1;
    idx      = {(pg_a1 || pg_b1), off[SLOT_W:1]};
    is_lo    = off[0];
  end

endmodule

// File: rtl/coef_ctrl_reg.sv
module coef_ctrl_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       running,
  input  logic       sample_start,
  output logic       adapt_en,
  output logic       active_bank,
  output logic       swap_req
);
  logic swap_now;

  assign swap_now = swap_req && sample_start && running && adapt_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      adapt_en    <= 1'b0;
      active_bank <= 1'b0;
      swap_req    <= 1'b0;
    end else begin
      if (ctrl_we) adapt_en <= ctrl_wdata[2];
      if (swap_now) active_bank <= ~active_bank;
      if (!running || !adapt_en || swap_now)
        swap_req <= 1'b0;
      else if (ctrl_we && ctrl_wdata[0] && ctrl_wdata[2])
        swap_req <= 1'b1;
    end
  end

  a_r5_req_self_clear: assert property (@(posedge clk) disable iff (rst)
    (swap_req && sample_start && running && adapt_en) |=> !swap_req);

  a_r6_toggle_on_swap: assert property (@(posedge clk) disable iff (rst)
    (swap_req && sample_start && running && adapt_en) |=> (active_bank != $past(active_bank)));

  a_r6_hold_without_swap: assert property (@(posedge clk) disable iff (rst)
    !(swap_req && sample_start && running && adapt_en) |=> $stable(active_bank));

  a_r8_stopped_no_req: assert property (@(posedge clk) disable iff (rst)
    !running |=> !swap_req);

endmodule

// File: rtl/coef_bank_mem.sv
module coef_bank_mem #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/coef_dbuf_store.sv
module coef_dbuf_store
  import coef_store_pkg::*;
#(
  parameter int NUM_COEF  = 64,
  parameter int PAGE_A0   = 8,
  parameter int PAGE_B0   = 12,
  parameter int COEF_REG0 = 8,
  localparam int IDX_W    = $clog2(NUM_COEF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_page,
  input  logic [7:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [IDX_W-1:0] dp_idx,
  output logic [15:0]      dp_coef,
  input  logic             sample_start,
  input  logic             running
);
  localparam int DEPTH = 2 * NUM_COEF;
  localparam int AW    = IDX_W + 1;

  logic             is_ctrl, is_coef, addr_bank, is_lo;
  logic [IDX_W-1:0] idx;
  logic             adapt_en, active_bank, swap_req;

  logic             init_busy;
  logic [AW-1:0]    init_cnt;
  logic [7:0]       hi_stage;
  logic             locked, tbank, coef_ok;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [15:0]      mem_wdata, host_q;
  rd_kind_t         rd_kind;
  logic [7:0]       ctrl_snap;

  coef_addr_decode #(
    .NUM_COEF(NUM_COEF), .PAGE_A0(PAGE_A0), .PAGE_B0(PAGE_B0),
    .CTRL_REG(1), .COEF_REG0(COEF_REG0)
  ) u_dec (
    .page(host_page), .addr(host_addr), .is_ctrl(is_ctrl), .is_coef(is_coef),
    .bank(addr_bank), .idx(idx), .is_lo(is_lo)
  );

  coef_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst),
    .ctrl_we(host_wr && is_ctrl && !init_busy), .ctrl_wdata(host_wdata),
    .running(running), .sample_start(sample_start),
    .adapt_en(adapt_en), .active_bank(active_bank), .swap_req(swap_req)
  );

  // post-reset sweep loading both banks
  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_cnt  <= '0;
    end else if (init_busy) begin
      init_cnt <= init_cnt + 1'b1;
      if (init_cnt == AW'(DEPTH - 1)) init_busy <= 1'b0;
    end
  end

  always_comb begin
    locked  = running && !adapt_en;
    tbank   = (running && adapt_en) ? ~active_bank : addr_bank;
    coef_ok = is_coef && !locked && !init_busy;
    if (init_busy) begin
      mem_we    = 1'b1;
      mem_waddr = init_cnt;
      mem_wdata = coef_default(int'(init_cnt[IDX_W-1:0]));
    end else begin
      mem_we    = host_wr && coef_ok && is_lo;
      mem_waddr = {tbank, idx};
      mem_wdata = {hi_stage, host_wdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hi_stage <= '0;
    else if (host_wr && coef_ok && !is_lo) hi_stage <= host_wdata;
  end

  coef_bank_mem #(.DEPTH(DEPTH), .WIDTH(16)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a({active_bank, dp_idx}), .rdata_a(dp_coef),
    .raddr_b({tbank, idx}), .rdata_b(host_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_kind   <= RK_ZERO;
      ctrl_snap <= '0;
    end else if (host_rd) begin
      ctrl_snap <= {5'b0, adapt_en, active_bank, swap_req};
      if (init_busy)    rd_kind <= RK_ZERO;
      else if (is_ctrl) rd_kind <= RK_CTRL;
      else if (coef_ok) rd_kind <= is_lo ? RK_LO : RK_HI;
      else              rd_kind <= RK_ZERO;
    end
  end

  always_comb begin
    case (rd_kind)
      RK_CTRL: host_rdata = ctrl_snap;
      RK_HI:   host_rdata = host_q[15:8];
      RK_LO:   host_rdata = host_q[7:0];
      default: host_rdata = 8'h00;
    endcase
  end

  a_r4_locked_no_write: assert property (@(posedge clk) disable iff (rst)
    (running && !adapt_en && !init_busy) |-> !mem_we);

  a_r7_write_inactive: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !init_busy && running && adapt_en) |-> (mem_waddr[IDX_W] != active_bank));

  a_r10_init_req_clear: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !swap_req);

endmodule

// File: tb/sim_coef_dbuf_store.sv
module sim_coef_dbuf_store;
  logic       clk = 1'b0;
  logic       rst;
  logic       host_wr, host_rd, sample_start, running;
  logic [7:0] host_page, host_addr, host_wdata, host_rdata;
  logic [5:0] dp_idx;
  logic [15:0] dp_coef;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coef_dbuf_store u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_page(host_page), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dp_idx(dp_idx), .dp_coef(dp_coef),
    .sample_start(sample_start), .running(running)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cpage(input bit b, input int k);
    return 8'((b ? 12 : 8) + k / 32);
  endfunction
  function automatic logic [7:0] creg(input int k);
    return 8'(8 + 2 * (k % 32));
  endfunction

  task automatic wr(input logic [7:0] p, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_page = p; host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] p, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_page = p; host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wcoef(input bit b, input int k, input logic [15:0] v);
    wr(cpage(b, k), creg(k), v[15:8]);
    wr(cpage(b, k), creg(k) + 8'd1, v[7:0]);
  endtask

  task automatic dp(input int k, output logic [15:0] v);
    @(negedge clk);
    dp_idx = 6'(k);
    @(negedge clk);
    v = dp_coef;
  endtask

  task automatic strobe();
    @(negedge clk);
    sample_start = 1'b1;
    @(negedge clk);
    sample_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    logic [15:0] v;
    // write during the init sweep must be ignored (R10)
    wcoef(1'b0, 3, 16'h1234);
    repeat (140) @(negedge clk);
    rd(8'd8, 8'd1, b);       check("R10 ctrl after reset", b, 8'h00);
    dp(0, v);                check("R10 default k0", v, 16'h7FFF);
    dp(1, v);                check("R10 default k1", v, 16'h0000);
    dp(35, v);               check("R1 R10 default k35 page 9", v, 16'h7FFF);
    dp(3, v);                check("R10 write during init ignored", v, 16'h0000);
    rd(cpage(1'b1, 10), creg(10), b); check("R2 R10 bank B default hi", b, 8'h7F);
  endtask

  task automatic t_stopped();
    logic [7:0] b;
    logic [15:0] v;
    running = 1'b0;
    wcoef(1'b0, 2, 16'h1234);
    dp(2, v);                check("R1 R8 write bank A stopped", v, 16'h1234);
    wcoef(1'b1, 2, 16'hABCD);
    rd(cpage(1'b1, 2), creg(2) + 8'd1, b); check("R2 R8 bank B lo", b, 8'hCD);
    dp(2, v);                check("R8 bank A untouched", v, 16'h1234);
    wcoef(1'b0, 40, 16'h8000);
    dp(40, v);               check("R1 page 9 coefficient", v, 16'h8000);
    wr(cpage(1'b0, 2), creg(2), 8'h55);
    dp(2, v);                check("R9 high byte alone", v, 16'h1234);
    wr(cpage(1'b0, 2), creg(2) + 8'd1, 8'h66);
    dp(2, v);                check("R9 low byte commits", v, 16'h5566);
    wr(8'd8, 8'd1, 8'h07);
    rd(8'd8, 8'd1, b);       check("R3 R8 request ignored stopped", b, 8'h04);
    strobe();
    rd(8'd8, 8'd1, b);       check("R8 no swap stopped", b, 8'h04);
    wr(8'd8, 8'd1, 8'hFB);
    rd(8'd8, 8'd1, b);       check("R3 bit2 cleared, high bits zero", b, 8'h00);
  endtask

  task automatic t_lock();
    logic [7:0] b;
    logic [15:0] v;
    running = 1'b1;
    wcoef(1'b0, 2, 16'h9999);
    rd(cpage(1'b0, 2), creg(2), b); check("R4 locked read zero", b, 8'h00);
    dp(2, v);                check("R4 locked write no effect", v, 16'h5566);
    wr(8'd8, 8'd1, 8'h01);
    rd(8'd8, 8'd1, b);       check("R5 no request without adaptive", b, 8'h00);
    running = 1'b0;
    rd(cpage(1'b0, 2), creg(2), b); check("R4 value kept after unlock", b, 8'h55);
  endtask

  task automatic t_adaptive();
    logic [7:0] b;
    logic [15:0] v;
    wr(8'd8, 8'd1, 8'h04);
    running = 1'b1;
    wcoef(1'b0, 7, 16'h4321);
    dp(7, v);                check("R7 active A untouched", v, 16'h0000);
    rd(cpage(1'b0, 7), creg(7) + 8'd1, b); check("R7 read redirected to B", b, 8'h21);
    wr(8'd8, 8'd1, 8'h05);
    repeat (3) @(negedge clk);
    rd(8'd8, 8'd1, b);       check("R5 request pending", b, 8'h05);
    dp(7, v);                check("R5 no swap before strobe", v, 16'h0000);
    strobe();
    rd(8'd8, 8'd1, b);       check("R5 R6 swapped to B, bit0 clear", b, 8'h06);
    dp(7, v);                check("R6 datapath sees B", v, 16'h4321);
    dp(2, v);                check("R6 B keeps earlier value", v, 16'hABCD);
    wcoef(1'b1, 7, 16'h1111);
    dp(7, v);                check("R7 write to B pages lands in A", v, 16'h4321);
    wr(8'd8, 8'd1, 8'h05);
    strobe();
    rd(8'd8, 8'd1, b);       check("R6 toggled back to A", b, 8'h04);
    dp(7, v);                check("R7 A holds redirected value", v, 16'h1111);
    running = 1'b0;
  endtask

  initial begin
    rst = 1'b1; host_wr = 1'b0; host_rd = 1'b0; sample_start = 1'b0; running = 1'b0;
    host_page = '0; host_addr = '0; host_wdata = '0; dp_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stopped();
    t_lock();
    t_adaptive();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule